// File: doc/BRIEF.md
# Received Flow-Control Frame Detector and Throttle

This block sits on the receive byte stream just after the MAC. It watches every frame for a MAC control frame addressed either to the reserved flow-control multicast address or to the local station address. When it finds one, it decodes whether the frame is a link-level PAUSE or a per-class priority flow-control (PFC) frame. It then reads the requested pause time, measured in quanta, and holds the matching throttle indication high for that time. One quantum is 512 bit times, and the parameter `QUANTUM_CYCLES` converts it to clock cycles.

The two kinds of frame are handled differently. A link-level PAUSE drives one link indication, and it can also halt local transmission when automatic halting is enabled. A PFC frame only raises the per-class indications and never halts transmission by itself. Each kind has its own forward-or-drop setting. A dropped frame never appears on the client side.

To make that choice before any byte is released, the stream passes through a fixed 16-beat delay line. The decision is known when the opcode arrives, so it is ready in time. Input frames must be contiguous: valid stays high from the start beat to the end beat. Idle cycles between frames are allowed. `NUM_CLASSES` may be 1 to 8.

Top module: `rx_pause_ctl`

## Requirements
- R1: A frame that is forwarded leaves on `out_*` exactly 16 cycles after each input beat, with the same data, start and end markers, and no beat added or removed.
- R2: A frame is a control frame only when all of the following hold. Bytes 0 to 5 (byte 0 first) equal 01-80-C2-00-00-01, or equal `cfg_station_addr` with byte 0 as its most significant byte. Bytes 12 and 13 are 0x88 and 0x08. Bytes 14 and 15 hold opcode 0x0001 (PAUSE) or 0x0101 (PFC). Any other frame is ordinary data.
- R3: A PAUSE frame whose end beat is byte index 18 or later loads the link timer. The quanta value is bytes 16 (high) and 17 (low). `rx_link_pause` is then high for quanta × `QUANTUM_CYCLES` cycles, starting the cycle after the end beat. A shorter frame has no effect, and a new load restarts the timer.
- R4: `tx_halt` is high exactly while `rx_link_pause` is high and `cfg_auto_halt` is 1; it is always low when `cfg_auto_halt` is 0.
- R5: A PFC frame whose end beat is byte index 34 or later loads timer n for each class n whose enable bit is set. The enable bit for class n is bit n of byte 17. The quanta for class n are bytes 18+2n (high) and 19+2n (low). `rx_class_pause[n]` is then high for quanta × `QUANTUM_CYCLES` cycles, starting the cycle after the end beat.
- R6: In a PFC frame, a class whose enable bit is clear keeps its timer unchanged.
- R7: A PFC frame never changes `rx_link_pause` or `tx_halt`.
- R8: A quanta value of zero clears the addressed timer, so the indication is low from the cycle after the end beat.
- R9: With `cfg_fwd_pause` = 0, a matching PAUSE frame produces no valid beats on the output. With `cfg_fwd_pause` = 1, it is forwarded like data. In both cases it still acts on the link timer.
- R10: `cfg_fwd_pfc` sets the same forward-or-drop behaviour for matching PFC frames, independently of `cfg_fwd_pause`.
- R11: A frame with an unmatched address or type is forwarded and affects no timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_data | input | 8 | Input byte |
| cfg_station_addr | input | 48 | Local station address, first byte in bits 47:40 |
| cfg_auto_halt | input | 1 | Let link PAUSE halt local transmission |
| cfg_fwd_pause | input | 1 | 1 forwards matching PAUSE frames, 0 drops them |
| cfg_fwd_pfc | input | 1 | 1 forwards matching PFC frames, 0 drops them |
| out_valid | output | 1 | Client beat valid |
| out_sop | output | 1 | Client first beat |
| out_eop | output | 1 | Client last beat |
| out_data | output | 8 | Client byte |
| rx_class_pause | output | NUM_CLASSES | Per-class throttle indication |
| rx_link_pause | output | 1 | Link-level pause timer running |
| tx_halt | output | 1 | Stop local transmission |

## Verification
The bench builds the block with `NUM_CLASSES` = 4 and `QUANTUM_CYCLES` = 2. With these values, a pause of a few quanta lasts only a few cycles, so each pause window can be measured exactly from its rising edge to its falling edge. The same settings let the bench send a long pause, then a zero-quanta frame or a PFC frame with that class disabled, while the first timer is still running. Only four classes are decoded, but the PFC frame still carries eight time slots, so the frame-length threshold and the field positions are exercised unchanged. Random back-to-back frames, mixing data, PAUSE and PFC with random forwarding settings, stress the drop decision at frame boundaries that have no idle cycle between them.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {FK_DATA, FK_PAUSE, FK_PFC} frame_kind_e;

  typedef struct packed {
    logic       valid;
    logic       sop;
    logic       eop;
    logic [7:0] data;
  } beat_t;

  localparam logic [47:0] CTRL_MCAST   = 48'h0180C2000001;
  localparam logic [15:0] CTRL_TYPE    = 16'h8808;
  localparam logic [15:0] OP_LINK      = 16'h0001;
  localparam logic [15:0] OP_CLASS     = 16'h0101;
  localparam int          HDR_BYTES    = 16;              // delay depth = bytes to decide
  localparam int          PAY_BYTES    = 18;              // bytes 16..33 captured
  localparam int          LINK_MIN_EOP = HDR_BYTES + 2;   // end beat index for PAUSE
  localparam int          CLS_MIN_EOP  = HDR_BYTES + PAY_BYTES;

  // Byte p (0 = first on the wire) of a 48-bit address
  function automatic logic [7:0] addr_byte(input logic [47:0] a, input int p);
    return a[8*(5-p) +: 8];
  endfunction

  function automatic frame_kind_e classify_op(input logic [15:0] op);
    if (op == OP_LINK)  return FK_PAUSE;
    if (op == OP_CLASS) return FK_PFC;
    return FK_DATA;
  endfunction

  // Pause quanta converted to clock cycles
  function automatic logic [31:0] pause_cycles(input logic [15:0] q, input int unsigned per);
    return 32'(q) * 32'(per);
  endfunction
endpackage

// File: rtl/pfd_parse.sv
module pfd_parse
  import pfd_pkg::*;
#(
  parameter int NUM_CLASSES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sop,
  input  logic                        in_eop,
  input  logic [7:0]                  in_data,
  input  logic [47:0]                 cfg_station_addr,
  input  logic                        cfg_fwd_pause,
  input  logic                        cfg_fwd_pfc,
  output logic                        ev_decide,
  output logic                        dec_drop,
  output logic                        ev_pause_load,
  output logic [15:0]                 pause_quanta,
  output logic                        ev_pfc_load,
  output logic [NUM_CLASSES-1:0]      pfc_enable,
  output logic [NUM_CLASSES-1:0][15:0] pfc_quanta
);
  logic [5:0]  idx_q, pos;
  logic        mc_q, st_q, ty_q, mc_n, st_n, ty_n, hit;
  logic [7:0]  op_hi_q;
  frame_kind_e kind_q, kind_now;
  logic [7:0]  pay_q [PAY_BYTES];

  assign pos = in_sop ? 6'd0 : idx_q;

  always_comb begin
    mc_n = mc_q;
    st_n = st_q;
    ty_n = ty_q;
    if (pos < 6'd6) begin
      mc_n = (in_data == addr_byte(CTRL_MCAST, int'(pos))) && (pos == 6'd0 || mc_q);
      st_n = (in_data == addr_byte(cfg_station_addr, int'(pos))) && (pos == 6'd0 || st_q);
    end
    if (pos == 6'd12)      ty_n = (in_data == CTRL_TYPE[15:8]);
    else if (pos == 6'd13) ty_n = ty_q && (in_data == CTRL_TYPE[7:0]);
  end

  assign hit       = (mc_q || st_q) && ty_q;
  assign kind_now  = hit ? classify_op({op_hi_q, in_data}) : FK_DATA;
  assign ev_decide = in_valid && (pos == 6'(HDR_BYTES - 1));
  assign dec_drop  = ((kind_now == FK_PAUSE) && !cfg_fwd_pause) ||
                     ((kind_now == FK_PFC)   && !cfg_fwd_pfc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      mc_q    <= 1'b0;
      st_q    <= 1'b0;
      ty_q    <= 1'b0;
      op_hi_q <= '0;
      kind_q  <= FK_DATA;
      for (int k = 0; k < PAY_BYTES; k++) pay_q[k] <= '0;
    end else if (in_valid) begin
      idx_q <= (pos == 6'd63) ? pos : pos + 6'd1;
      mc_q  <= mc_n;
      st_q  <= st_n;
      ty_q  <= ty_n;
      if (pos == 6'd14) op_hi_q <= in_data;
      if (in_sop) kind_q <= FK_DATA;
      else if (pos == 6'(HDR_BYTES - 1)) kind_q <= kind_now;
      for (int k = 0; k < PAY_BYTES; k++)
        if (pos == 6'(HDR_BYTES + k)) pay_q[k] <= in_data;
    end
  end

  assign ev_pause_load = in_valid && in_eop && (kind_q == FK_PAUSE) && (pos >= 6'(LINK_MIN_EOP));
  assign ev_pfc_load   = in_valid && in_eop && (kind_q == FK_PFC)   && (pos >= 6'(CLS_MIN_EOP));
  assign pause_quanta  = {pay_q[0], pay_q[1]};

  for (genvar n = 0; n < NUM_CLASSES; n++) begin : g_cls
    assign pfc_enable[n] = pay_q[1][n];
    assign pfc_quanta[n] = {pay_q[2 + 2*n], pay_q[3 + 2*n]};
  end

  // R3: a timer load can only come from a completed frame, never from a first beat
  assert_load_not_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pause_load || ev_pfc_load) |-> !in_sop);
endmodule

// File: rtl/pfd_qtimer.sv
module pfd_qtimer
  import pfd_pkg::*;
#(
  parameter int QUANTUM_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] quanta,
  output logic        busy
);
  localparam int CW = 16 + $clog2(QUANTUM_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= CW'(pause_cycles(quanta, QUANTUM_CYCLES));
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  assert_xon_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && quanta == 16'd0) |=> !busy);
  assert_load_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && quanta != 16'd0) |=> busy);
  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pfd_delay.sv
module pfd_delay
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [7:0] in_data,
  input  logic       ev_decide,
  input  logic       dec_drop,
  output logic       out_valid,
  output logic       out_sop,
  output logic       out_eop,
  output logic [7:0] out_data
);
  beat_t stage_q [HDR_BYTES];
  beat_t tail;
  logic  drop_q;

  assign tail = stage_q[HDR_BYTES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < HDR_BYTES; k++) stage_q[k] <= '0;
      drop_q <= 1'b0;
    end else begin
      stage_q[0] <= '{valid: in_valid, sop: in_sop, eop: in_eop, data: in_data};
      for (int k = 1; k < HDR_BYTES; k++) stage_q[k] <= stage_q[k-1];
      // a new decision wins over the end of the frame leaving in the same cycle
      if (ev_decide)                   drop_q <= dec_drop;
      else if (tail.valid && tail.eop) drop_q <= 1'b0;
    end
  end

  assign out_valid = tail.valid && !drop_q;
  assign out_sop   = tail.sop   && !drop_q;
  assign out_eop   = tail.eop   && !drop_q;
  assign out_data  = tail.data;

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, HDR_BYTES));
  assert_sop_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> $past(in_sop, HDR_BYTES));
  assert_decide_before_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_decide |=> (tail.valid && tail.sop));
endmodule

// File: rtl/rx_pause_ctl.sv
module rx_pause_ctl
  import pfd_pkg::*;
#(
  parameter int NUM_CLASSES    = 8,
  parameter int QUANTUM_CYCLES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sop,
  input  logic                   in_eop,
  input  logic [7:0]             in_data,
  input  logic [47:0]            cfg_station_addr,
  input  logic                   cfg_auto_halt,
  input  logic                   cfg_fwd_pause,
  input  logic                   cfg_fwd_pfc,
  output logic                   out_valid,
  output logic                   out_sop,
  output logic                   out_eop,
  output logic [7:0]             out_data,
  output logic [NUM_CLASSES-1:0] rx_class_pause,
  output logic                   rx_link_pause,
  output logic                   tx_halt
);
  logic                         ev_decide, dec_drop, ev_pause_load, ev_pfc_load;
  logic [15:0]                  pause_quanta;
  logic [NUM_CLASSES-1:0]       pfc_enable;
  logic [NUM_CLASSES-1:0][15:0] pfc_quanta;

  pfd_parse #(.NUM_CLASSES(NUM_CLASSES)) u_parse (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .cfg_station_addr(cfg_station_addr),
    .cfg_fwd_pause(cfg_fwd_pause), .cfg_fwd_pfc(cfg_fwd_pfc),
    .ev_decide(ev_decide), .dec_drop(dec_drop),
    .ev_pause_load(ev_pause_load), .pause_quanta(pause_quanta),
    .ev_pfc_load(ev_pfc_load), .pfc_enable(pfc_enable), .pfc_quanta(pfc_quanta)
  );

  pfd_delay u_delay (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .ev_decide(ev_decide), .dec_drop(dec_drop),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  pfd_qtimer #(.QUANTUM_CYCLES(QUANTUM_CYCLES)) u_link (
    .clk(clk), .rst_n(rst_n),
    .load(ev_pause_load), .quanta(pause_quanta), .busy(rx_link_pause)
  );

  for (genvar n = 0; n < NUM_CLASSES; n++) begin : g_tmr
    pfd_qtimer #(.QUANTUM_CYCLES(QUANTUM_CYCLES)) u_cls (
      .clk(clk), .rst_n(rst_n),
      .load(ev_pfc_load && pfc_enable[n]), .quanta(pfc_quanta[n]),
      .busy(rx_class_pause[n])
    );

    assert_class_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_class_pause[n]) |-> $past(ev_pfc_load && pfc_enable[n]));
  end

  assign tx_halt = cfg_auto_halt && rx_link_pause;

  assert_pfc_no_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pfc_load && !rx_link_pause) |=> !rx_link_pause);
endmodule

// File: tb/test_rx_pause_ctl.sv
module test_rx_pause_ctl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NC = 4;
  localparam int QC = 2;
  localparam logic [47:0] MCAST   = 48'h0180C2000001;
  localparam logic [47:0] STATION = 48'h021122334455;
  localparam logic [47:0] OTHER   = 48'h0180C2000002;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic cfg_auto_halt = 1'b1, cfg_fwd_pause = 1'b1, cfg_fwd_pfc = 1'b1;
  logic out_valid, out_sop, out_eop;
  logic [7:0] out_data;
  logic [NC-1:0] rx_class_pause;
  logic rx_link_pause, tx_halt;

  always #2 clk = ~clk;

  rx_pause_ctl #(.NUM_CLASSES(NC), .QUANTUM_CYCLES(QC)) i_rx_pause_ctl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .cfg_station_addr(STATION), .cfg_auto_halt(cfg_auto_halt),
    .cfg_fwd_pause(cfg_fwd_pause), .cfg_fwd_pfc(cfg_fwd_pfc),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .rx_class_pause(rx_class_pause), .rx_link_pause(rx_link_pause), .tx_halt(tx_halt)
  );

  int errors = 0, checks = 0, cyc = 0, last_eop = 0, halt_cnt = 0;
  int cur_run [NC+1];
  int last_run [NC+1];
  logic [9:0] exp_q [$];
  logic [9:0] got_q [$];
  logic [7:0] fb [0:127];

  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor: stream capture and run lengths of each indication
  always @(negedge clk) begin
    if (out_valid) got_q.push_back({out_sop, out_eop, out_data});
    if (tx_halt) halt_cnt++;
    for (int k = 0; k <= NC; k++) begin
      if ((k == NC) ? rx_link_pause : rx_class_pause[k]) cur_run[k]++;
      else if (cur_run[k] > 0) begin
        last_run[k] = cur_run[k];
        cur_run[k] = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic clear_runs();
    for (int k = 0; k <= NC; k++) last_run[k] = 0;
    halt_cnt = 0;
  endtask

  task automatic check_stream(input string req);
    int bad = 0;
    chk({req, " beat count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (got_q[i] != exp_q[i]) bad++;
    chk({req, " beat mismatches"}, bad, 0);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic send(input int len, input bit fwd, input int gap);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_data  = fb[i];
      if (fwd) exp_q.push_back({(i == 0), (i == len - 1), fb[i]});
    end
    last_eop = cyc;
    if (gap > 0) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      repeat (gap - 1) @(posedge clk);
    end
  endtask

  task automatic mk_frame(input logic [47:0] da, input logic [15:0] ety,
                          input logic [15:0] op, input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    for (int k = 0; k < 6; k++) fb[k] = da[8*(5-k) +: 8];
    fb[6] = 8'h02;
    fb[12] = ety[15:8]; fb[13] = ety[7:0];
    fb[14] = op[15:8];  fb[15] = op[7:0];
  endtask

  task automatic send_pause(input logic [47:0] da, input logic [15:0] q,
                            input int len, input bit fwd, input int gap);
    mk_frame(da, 16'h8808, 16'h0001, len);
    fb[16] = q[15:8]; fb[17] = q[7:0];
    send(len, fwd, gap);
  endtask

  task automatic send_pfc(input logic [47:0] da, input logic [7:0] en,
                          input logic [3:0][15:0] q, input bit fwd, input int gap);
    mk_frame(da, 16'h8808, 16'h0101, 40);
    fb[16] = 8'h00; fb[17] = en;
    for (int c = 0; c < 8; c++) begin
      fb[18 + 2*c] = (c < 4) ? q[c][15:8] : 8'h00;
      fb[19 + 2*c] = (c < 4) ? q[c][7:0]  : 8'h00;
    end
    send(40, fwd, gap);
  endtask

  // expected forwarding of a frame from the requirements
  function automatic bit exp_fwd(input bit match, input int kind, input bit fp, input bit fc);
    if (!match) return 1'b1;
    if (kind == 1) return fp;
    if (kind == 2) return fc;
    return 1'b1;
  endfunction

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int e1;
    void'($urandom(32'd4242));
    for (int k = 0; k <= NC; k++) begin cur_run[k] = 0; last_run[k] = 0; end
    wait_cyc(4);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("reset out_valid", int'(out_valid), 0);
    chk("reset R3 link pause", int'(rx_link_pause), 0);
    chk("reset R5 class pause", int'(rx_class_pause), 0);
    chk("reset R4 tx_halt", int'(tx_halt), 0);

    // R1: plain data frame passes intact
    mk_frame(STATION, 16'h0800, 16'h4500, 24);
    send(24, 1'b1, 1);
    wait_cyc(30);
    check_stream("R1 data frame");

    // R3 R4 R2: PAUSE to the multicast address, auto halt on
    clear_runs();
    send_pause(MCAST, 16'd7, 30, 1'b1, 1);
    wait_cyc(40);
    chk("R3 link pause length", last_run[NC], 7 * QC);
    chk("R4 halt cycles auto on", halt_cnt, 7 * QC);
    check_stream("R9 pause forwarded");

    // R2 R4: station address, auto halt off
    cfg_auto_halt = 1'b0;
    clear_runs();
    send_pause(STATION, 16'd5, 30, 1'b1, 1);
    wait_cyc(40);
    chk("R2 station address pause length", last_run[NC], 5 * QC);
    chk("R4 no halt when disabled", halt_cnt, 0);
    check_stream("R2 station pause forwarded");
    cfg_auto_halt = 1'b1;

    // R8: long pause ended by zero quanta
    clear_runs();
    send_pause(MCAST, 16'd200, 30, 1'b1, 10);
    e1 = last_eop;
    send_pause(MCAST, 16'd0, 30, 1'b1, 1);
    wait_cyc(20);
    chk("R8 xon ends pause", last_run[NC], last_eop - e1);
    chk("R8 halt ends with xon", halt_cnt, last_eop - e1);
    check_stream("R8 stream");

    // R5 R6 R7: PFC with classes 0 and 2 enabled
    clear_runs();
    send_pfc(MCAST, 8'b0000_0101, {16'd6, 16'd4, 16'd9, 16'd3}, 1'b1, 1);
    wait_cyc(40);
    chk("R5 class0 length", last_run[0], 3 * QC);
    chk("R5 class2 length", last_run[2], 4 * QC);
    chk("R6 class1 untouched", last_run[1], 0);
    chk("R6 class3 untouched", last_run[3], 0);
    chk("R7 no link pause from pfc", last_run[NC], 0);
    chk("R7 no halt from pfc", halt_cnt, 0);
    check_stream("R10 pfc forwarded");

    // R6: disabled class keeps a running timer
    clear_runs();
    send_pfc(STATION, 8'b0000_0010, {16'd0, 16'd0, 16'd50, 16'd0}, 1'b1, 20);
    send_pfc(MCAST, 8'b0000_0001, {16'd0, 16'd0, 16'd1, 16'd2}, 1'b1, 1);
    wait_cyc(120);
    chk("R6 class1 kept running", last_run[1], 50 * QC);
    chk("R5 class0 second frame", last_run[0], 2 * QC);
    check_stream("R6 stream");

    // R11: unmatched address and wrong type
    clear_runs();
    send_pause(OTHER, 16'd9, 30, 1'b1, 2);
    mk_frame(MCAST, 16'h8809, 16'h0001, 30);
    fb[16] = 8'h00; fb[17] = 8'h09;
    send(30, 1'b1, 1);
    wait_cyc(40);
    chk("R11 no pause on mismatch", last_run[NC], 0);
    check_stream("R11 mismatches forwarded");

    // R9 R10: drop PAUSE, keep PFC
    cfg_fwd_pause = 1'b0;
    clear_runs();
    send_pause(MCAST, 16'd3, 30, 1'b0, 1);
    send_pfc(MCAST, 8'h01, {16'd0, 16'd0, 16'd0, 16'd1}, 1'b1, 1);
    wait_cyc(40);
    chk("R9 dropped pause still acts", last_run[NC], 3 * QC);
    check_stream("R9 pause dropped R10 pfc kept");

    // R10 R9: drop PFC, keep PAUSE
    cfg_fwd_pause = 1'b1; cfg_fwd_pfc = 1'b0;
    send_pfc(STATION, 8'h01, {16'd0, 16'd0, 16'd0, 16'd1}, 1'b0, 0);
    send_pause(MCAST, 16'd1, 30, 1'b1, 1);
    wait_cyc(40);
    check_stream("R10 pfc dropped R9 pause kept");
    cfg_fwd_pfc = 1'b1;

    // R3 boundary: PAUSE ending at byte 17 has no effect
    clear_runs();
    send_pause(MCAST, 16'd4, 18, 1'b1, 1);
    wait_cyc(30);
    chk("R3 short pause ignored", last_run[NC], 0);
    send_pause(MCAST, 16'd4, 19, 1'b1, 1);
    wait_cyc(30);
    chk("R3 minimum pause accepted", last_run[NC], 4 * QC);
    check_stream("R3 boundary stream");

    // R1 R9 R10 R11: random back-to-back mix
    for (int f = 0; f < 60; f++) begin
      int kind = int'($urandom % 3);
      int dsel = int'($urandom % 3);
      int len  = 20 + int'($urandom % 40);
      int gap  = int'($urandom % 3);
      logic [47:0] da = (dsel == 0) ? MCAST : (dsel == 1) ? STATION : OTHER;
      bit fwd;
      cfg_fwd_pause = 1'($urandom);
      cfg_fwd_pfc   = 1'($urandom);
      fwd = exp_fwd(dsel < 2, kind, cfg_fwd_pause, cfg_fwd_pfc);
      mk_frame(da, (kind == 0) ? 16'h0800 : 16'h8808,
               (kind == 2) ? 16'h0101 : 16'h0001, len);
      fb[16] = 8'h00; fb[17] = 8'($urandom % 4);
      send(len, fwd, gap);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    wait_cyc(40);
    check_stream("R1 R9 R10 R11 random mix");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule